// File: doc/BRIEF.md
# Interrupt Flag and Source Aggregator

This block holds a small set of shared event flags that several execution engines raise, and merges them with per-channel FIFO readiness into one masked interrupt request. Software sees the flags through a register it can read and clear bit by bit, and it can also force flags on through a second register. Engines raise a flag by pulsing a strobe together with a flag index. More than one engine may strike in the same cycle.

The interrupt sources form a fixed 12-bit vector. Bits 3:0 carry receive-not-empty for channels 0 to 3. Bits 7:4 carry transmit-not-full for channels 0 to 3. Bits 11:8 carry flags 0 to 3. An enable register gates this vector. Software changes the enable register only through a set alias and a clear alias, so no read-modify-write sequence is needed. The gated vector can be read back, and its OR drives a registered interrupt line.

The register bus uses a 3-bit address. Address 0 is the flag register. Address 1 is the force register. Address 2 is the enable set alias and address 3 is the enable clear alias; reading either returns the enable register. Address 4 is the masked status. Any other address reads as zero.

Top module: `intr_aggregator`

## Requirements
- R1: After reset, all flags, all enable bits and the interrupt line are 0.
- R2: A bus write to address 0 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: A bus write to address 1 sets every flag whose data bit is 1. Reading address 1 returns 0.
- R4: An engine strobe `eng_set_vld[e]` with index `eng_set_idx[3e+2:3e]` sets that flag on the next clock edge. Strobes from several engines in the same cycle all take effect.
- R5: When an engine set and a bus clear address the same flag in the same cycle, the flag ends up set.
- R6: Raw source bit k, for k in 0..3, is `rx_nempty[k]`. Bit 4+k is `tx_nfull[k]`. Bit 8+k is flag k.
- R7: Flags 4 to 7 never appear in the masked status and never raise the interrupt line.
- R8: A write to address 2 ORs its data into the 12-bit enable register. Reads of address 2 and address 3 return the enable register.
- R9: A write to address 3 clears the enable bits whose data bits are 1.
- R10: Reading address 4 returns the raw source vector ANDed with the enable register.
- R11: `irq_o` is a register that holds the OR of the masked status from the previous cycle. It therefore drops one cycle after the last active source bit or its enable bit is cleared.
- R12: Reads have no side effects. A cycle with no write and no engine strobe leaves both the flags and the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 12 | Bus write data |
| bus_rdata | output | 12 | Read data for `bus_addr`, combinational |
| rx_nempty | input | 4 | Receive-not-empty per channel |
| tx_nfull | input | 4 | Transmit-not-full per channel |
| eng_set_vld | input | 4 | Flag set strobe per engine |
| eng_set_idx | input | 12 | Flag index per engine, 3 bits each |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following per-flag update rules: clear by write-1, force, engine set, and set winning over clear. They also check the enable set and clear aliases, that state holds when the bus is idle, and that the interrupt line follows the gated sources one cycle later. Other properties can only be shown by the bench's scenarios, which compare every read against a behavioural model. These are the exact bit layout of the raw vector as seen through the masked status, the masking of flags 4 to 7, the reset values, and the read decode of every address.

// File: rtl/intr_aggregator_pkg.sv
package intr_aggregator_pkg;

    typedef enum logic [2:0] {
        SEL_FLAGS  = 3'd0,
        SEL_FORCE  = 3'd1,
        SEL_EN_SET = 3'd2,
        SEL_EN_CLR = 3'd3,
        SEL_MSTAT  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/aggr_flag_bank.sv
module aggr_flag_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int NUM_ENG   = 4,
    parameter int IDX_W     = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_FLAGS-1:0]     clr_mask,
    input  logic [NUM_FLAGS-1:0]     force_mask,
    input  logic [NUM_ENG-1:0]       eng_vld,
    input  logic [NUM_ENG*IDX_W-1:0] eng_idx,
    output logic [NUM_FLAGS-1:0]     flags_q
);
    logic [NUM_FLAGS-1:0] eng_hit [NUM_ENG];
    logic [NUM_FLAGS-1:0] eng_any;
    logic [NUM_FLAGS-1:0] flags_d;

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        always_comb begin
            eng_hit[e] = '0;
            if (eng_vld[e]) begin
                eng_hit[e][eng_idx[e*IDX_W +: IDX_W]] = 1'b1;
            end
        end
    end

    always_comb begin
        eng_any = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            eng_any = eng_any | eng_hit[e];
        end
        // set sources are applied after the clear, so a set wins
        flags_d = (flags_q & ~clr_mask) | force_mask | eng_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end
endmodule

// File: rtl/aggr_enable_reg.sv
module aggr_enable_reg #(
    parameter int RAW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [RAW_W-1:0] mask,
    output logic [RAW_W-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (set_en) en_q <= en_q | mask;
        else if (clr_en) en_q <= en_q & ~mask;
    end
endmodule

// File: rtl/aggr_irq_merge.sv
module aggr_irq_merge #(
    parameter int NUM_CHAN       = 4,
    parameter int NUM_LINE_FLAGS = 4,
    parameter int RAW_W          = 2*NUM_CHAN + NUM_LINE_FLAGS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CHAN-1:0]       rx_nempty,
    input  logic [NUM_CHAN-1:0]       tx_nfull,
    input  logic [NUM_LINE_FLAGS-1:0] line_flags,
    input  logic [RAW_W-1:0]          en_q,
    output logic [RAW_W-1:0]          mstat,
    output logic                      irq_q
);
    logic [RAW_W-1:0] raw;

    always_comb begin
        raw   = {line_flags, tx_nfull, rx_nempty};
        mstat = raw & en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |mstat;
    end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
    import intr_aggregator_pkg::*;
#(
    parameter int NUM_CHAN       = 4,
    parameter int NUM_ENG        = 4,
    parameter int NUM_FLAGS      = 8,
    parameter int NUM_LINE_FLAGS = 4,
    localparam int RAW_W         = 2*NUM_CHAN + NUM_LINE_FLAGS,
    localparam int IDX_W         = $clog2(NUM_FLAGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [2:0]               bus_addr,
    input  logic [RAW_W-1:0]         bus_wdata,
    output logic [RAW_W-1:0]         bus_rdata,
    input  logic [NUM_CHAN-1:0]      rx_nempty,
    input  logic [NUM_CHAN-1:0]      tx_nfull,
    input  logic [NUM_ENG-1:0]       eng_set_vld,
    input  logic [NUM_ENG*IDX_W-1:0] eng_set_idx,
    output logic                     irq_o
);
    reg_sel_e             sel;
    logic [NUM_FLAGS-1:0] clr_mask, force_mask, flags_q;
    logic                 en_set, en_clr;
    logic [RAW_W-1:0]     en_q, mstat;

    always_comb begin
        sel        = reg_sel_e'(bus_addr);
        clr_mask   = (bus_wr && sel == SEL_FLAGS) ? bus_wdata[NUM_FLAGS-1:0] : '0;
        force_mask = (bus_wr && sel == SEL_FORCE) ? bus_wdata[NUM_FLAGS-1:0] : '0;
        en_set     = bus_wr && sel == SEL_EN_SET;
        en_clr     = bus_wr && sel == SEL_EN_CLR;
    end

    aggr_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .NUM_ENG(NUM_ENG), .IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .force_mask(force_mask),
        .eng_vld(eng_set_vld), .eng_idx(eng_set_idx), .flags_q(flags_q)
    );

    aggr_enable_reg #(.RAW_W(RAW_W)) u_en (
        .clk(clk), .rst_n(rst_n), .set_en(en_set), .clr_en(en_clr),
        .mask(bus_wdata), .en_q(en_q)
    );

    aggr_irq_merge #(.NUM_CHAN(NUM_CHAN), .NUM_LINE_FLAGS(NUM_LINE_FLAGS), .RAW_W(RAW_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .rx_nempty(rx_nempty), .tx_nfull(tx_nfull),
        .line_flags(flags_q[NUM_LINE_FLAGS-1:0]), .en_q(en_q), .mstat(mstat), .irq_q(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_FLAGS:              bus_rdata[NUM_FLAGS-1:0] = flags_q;
            SEL_EN_SET, SEL_EN_CLR: bus_rdata = en_q;
            SEL_MSTAT:              bus_rdata = mstat;
            default:                bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intr_aggregator_chk.sv
module intr_aggregator_chk #(
    parameter int NUM_CHAN       = 4,
    parameter int NUM_ENG        = 4,
    parameter int NUM_FLAGS      = 8,
    parameter int NUM_LINE_FLAGS = 4,
    parameter int RAW_W          = 12,
    parameter int IDX_W          = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [2:0]               bus_addr,
    input logic [RAW_W-1:0]         bus_wdata,
    input logic [NUM_CHAN-1:0]      rx_nempty,
    input logic [NUM_CHAN-1:0]      tx_nfull,
    input logic [NUM_ENG-1:0]       eng_set_vld,
    input logic [NUM_ENG*IDX_W-1:0] eng_set_idx,
    input logic [NUM_FLAGS-1:0]     flags,
    input logic [RAW_W-1:0]         en,
    input logic                     irq_o
);
    logic [NUM_FLAGS-1:0] hit;
    logic [RAW_W-1:0]     src;
    logic [RAW_W-1:0]     wmask;

    always_comb begin
        hit = '0;
        for (int e = 0; e < NUM_ENG; e++) begin
            if (eng_set_vld[e]) hit[eng_set_idx[e*IDX_W +: IDX_W]] = 1'b1;
        end
        src   = {flags[NUM_LINE_FLAGS-1:0], tx_nfull, rx_nempty};
        wmask = bus_wdata;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assert_engine_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flags[i]);
        // same-cycle set and clear: set must win
        assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && bus_wr && bus_addr == 3'd0 && bus_wdata[i]) |=> flags[i]);
        assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 3'd0 && bus_wdata[i] && !hit[i]) |=> !flags[i]);
        assert_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 3'd1 && bus_wdata[i]) |=> flags[i]);
    end

    assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> ((en & $past(wmask)) == $past(wmask)));
    assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3) |=> ((en & $past(wmask)) == '0));
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && eng_set_vld == '0) |=> ($stable(flags) && $stable(en)));
    assert_irq_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src & en)) |=> irq_o);
    assert_irq_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src & en)) |=> !irq_o);
endmodule

bind intr_aggregator intr_aggregator_chk #(
    .NUM_CHAN(NUM_CHAN), .NUM_ENG(NUM_ENG), .NUM_FLAGS(NUM_FLAGS),
    .NUM_LINE_FLAGS(NUM_LINE_FLAGS), .RAW_W(RAW_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rx_nempty(rx_nempty), .tx_nfull(tx_nfull),
    .eng_set_vld(eng_set_vld), .eng_set_idx(eng_set_idx),
    .flags(flags_q), .en(en_q), .irq_o(irq_o)
);

// File: tb/intr_aggregator_tb.sv
module intr_aggregator_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [11:0] bus_wdata = '0;
    logic [11:0] bus_rdata;
    logic [3:0]  rx_nempty = '0;
    logic [3:0]  tx_nfull = '0;
    logic [3:0]  eng_set_vld = '0;
    logic [11:0] eng_set_idx = '0;
    logic        irq_o;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference state
    int m_flags = 0;
    int m_en = 0;
    int m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_nempty(rx_nempty),
        .tx_nfull(tx_nfull), .eng_set_vld(eng_set_vld), .eng_set_idx(eng_set_idx),
        .irq_o(irq_o)
    );

    function automatic int model_read(int addr);
        int raw;
        raw = (int'(rx_nempty)) | (int'(tx_nfull) << 4) | ((m_flags & 'hF) << 8);
        case (addr)
            0:       return m_flags;
            2, 3:    return m_en;
            4:       return raw & m_en;
            default: return 0;
        endcase
    endfunction

    task automatic step(input bit wr, input int addr, input int wdata,
                        input int rx, input int tx, input int vld, input int idx,
                        input string req);
        int exp_rd, raw, setm;
        @(negedge clk);
        bus_wr = wr; bus_addr = 3'(addr); bus_wdata = 12'(wdata);
        rx_nempty = 4'(rx); tx_nfull = 4'(tx);
        eng_set_vld = 4'(vld); eng_set_idx = 12'(idx);
        #1;
        exp_rd = model_read(addr);
        vectors++;
        if (int'(bus_rdata) != exp_rd) begin
            miscompares++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", req, addr, bus_rdata, exp_rd);
        end
        vectors++;
        if (int'(irq_o) != m_irq) begin
            miscompares++;
            $display("FAIL %s irq actual=%0d expected=%0d", req, irq_o, m_irq);
        end
        @(posedge clk);
        raw = rx | (tx << 4) | ((m_flags & 'hF) << 8);
        m_irq = ((raw & m_en) != 0) ? 1 : 0;
        setm = 0;
        for (int e = 0; e < 4; e++) begin
            if (vld[e]) setm |= 1 << ((idx >> (3*e)) & 7);
        end
        if (wr && addr == 0) m_flags &= ~(wdata & 'hFF);
        if (wr && addr == 1) m_flags |= (wdata & 'hFF);
        m_flags |= setm;
        if (wr && addr == 2) m_en |= wdata & 'hFFF;
        if (wr && addr == 3) m_en &= ~wdata & 'hFFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 2, 0, 0, 0, 0, 0, "R1");
        step(0, 4, 0, 'hF, 'hF, 0, 0, "R1");
        // R3 force, read back, force reads zero
        step(1, 1, 'hA5, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, 0, "R3");
        // R2 write-1 clear, write-0 no effect
        step(1, 0, 'h05, 0, 0, 0, 0, "R2");
        step(1, 0, 'h00, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, "R2");
        // R4 two engines in one cycle: eng0 idx6, eng1 idx1
        step(0, 0, 0, 0, 0, 'b0011, (1 << 3) | 6, "R4");
        step(0, 0, 0, 0, 0, 'b1000, (3 << 9), "R4");
        step(0, 0, 0, 0, 0, 0, 0, "R4");
        // R5 engine set and bus clear on flag 1 together
        step(1, 0, 'h02, 0, 0, 'b0100, (1 << 6), "R5");
        step(0, 0, 0, 0, 0, 0, 0, "R5");
        // R12 reads with no writes change nothing
        step(0, 4, 0, 0, 0, 0, 0, "R12");
        step(0, 0, 0, 0, 0, 0, 0, "R12");
        step(0, 3, 0, 0, 0, 0, 0, "R12");
        // R8 enable set alias
        step(1, 2, 'h00F, 0, 0, 0, 0, "R8");
        step(1, 2, 'hFF0, 0, 0, 0, 0, "R8");
        step(0, 2, 0, 0, 0, 0, 0, "R8");
        // R6/R10 layout through masked status
        step(1, 0, 'hFF, 0, 0, 0, 0, "R6");
        step(0, 4, 0, 'h5, 'hA, 0, 0, "R6");
        step(1, 1, 'h09, 'h5, 'hA, 0, 0, "R10");
        step(0, 4, 0, 'h5, 'hA, 0, 0, "R10");
        step(0, 4, 0, 'h2, 'h0, 0, 0, "R11");
        // R7 high flags never reach status or line
        step(1, 0, 'hFF, 0, 0, 0, 0, "R7");
        step(1, 1, 'hF0, 0, 0, 0, 0, "R7");
        step(0, 4, 0, 0, 0, 0, 0, "R7");
        step(0, 4, 0, 0, 0, 0, 0, "R7");
        // R9 clear alias
        step(1, 3, 'h0F0, 'hF, 'hF, 0, 0, "R9");
        step(0, 4, 0, 'hF, 'hF, 0, 0, "R9");
        step(0, 3, 0, 0, 0, 0, 0, "R9");
        // R11 line drop one cycle after source clear
        step(1, 1, 'h01, 0, 0, 0, 0, "R11");
        step(0, 4, 0, 0, 0, 0, 0, "R11");
        step(1, 0, 'h01, 0, 0, 0, 0, "R11");
        step(0, 4, 0, 0, 0, 0, 0, "R11");
        step(0, 4, 0, 0, 0, 0, 0, "R11");
        // R11 line drop after enable clear
        step(0, 4, 0, 'h1, 0, 0, 0, "R11");
        step(1, 3, 'h001, 'h1, 0, 0, 0, "R11");
        step(0, 4, 0, 'h1, 0, 0, 0, "R11");
        step(0, 5, 0, 'h1, 0, 0, 0, "R11");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule